// File: doc/BRIEF.md
# Fail-Safe Clock Monitor and Switch

This block guards the system clock of a chip against a stopped primary oscillator. It compares the primary clock with an always-running internal reference clock, and the reference clock also serves as the fallback source. Each rising primary edge flips a toggle flop. The toggle is synchronised into the reference domain, where a counter measures how long the primary clock has been silent. When the silence lasts a full timeout window, the block latches a failure and hands the system clock over to the reference clock. The handover is glitch-free and break-before-make.

The failover is sticky. A primary clock that comes back does not reclaim the system clock. Software must first clear the failure flag, and only then can it request a return to the primary source. Monitoring is suspended while the chip sleeps. After reset, or when the chip leaves sleep, monitoring is armed again. The primary-clock type selects when monitoring starts: immediately for the externally driven and RC-type sources, or after a start-up run of primary edges for crystal sources. A failure always raises the interrupt request when interrupts are enabled. A failure raises the wake request only when interrupts are enabled and the chip is in idle or sleep, so with interrupts disabled the chip stays in its low-power mode and keeps running from the reference clock.

All control inputs are sampled on the rising edge of `ref_clk`. `flag_clr` and `ret_req` are single-cycle pulses in that domain. The reference clock must run at more than twice the primary frequency so that every primary edge is seen.

Top module: `fsafe_clk_guard`

## Requirements
- R1: After reset is released with the primary clock running, `fail_flag`, `fail_irq` and `wake_req` are 0, and `sys_clk` follows `pri_clk` once the enable synchroniser has settled.
- R2: With `pri_kind` 0 (external drive), 1 (RC) or 2 (internal RC), detection is armed from the first reference cycle after reset release, with no start-up wait.
- R3: With `pri_kind` 3 (crystal), no failure is detected until TMO_CYC... start-up count: until SU_CYC (1024) primary rising edges have been counted since reset release or since the last exit from sleep.
- R4: `fail_flag` sets once the primary clock has shown no rising edge for TMO_CYC (64) reference cycles. It does not set after a gap of 40 reference cycles.
- R5: After a failure, `sys_clk` is driven from `ref_clk`.
- R6: The failover is latched: `fail_flag` stays set and `sys_clk` stays on `ref_clk` after the primary clock resumes.
- R7: `fail_irq` is `fail_flag` gated by `irq_en`. `wake_req` is `fail_irq` gated by `pm_idle` or `pm_sleep`. With `irq_en` low, neither output rises, even though the failure is still flagged.
- R8: `ret_req` has no effect on clock selection in any cycle where `fail_flag` is set, including the cycle in which `flag_clr` is pulsed.
- R9: A `flag_clr` pulse clears `fail_flag`. If the timeout condition holds in the same cycle, the set wins and the flag stays 1.
- R10: Once the flag is clear, a `ret_req` pulse moves `sys_clk` back to `pri_clk`.
- R11: While `pm_sleep` is high, no new failure is detected. After sleep exit, detection is armed again.
- R12: The clock handover is break-before-make. The two source enables are never on together, and `sys_clk` shows no high or low phase shorter than half a reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Primary system clock under watch |
| ref_clk | input | 1 | Always-running internal reference and fallback clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_kind | input | 2 | Primary clock type: 0 external, 1 RC, 2 internal RC, 3 crystal |
| pm_idle | input | 1 | Chip is in idle mode (CPU halted, clocks running) |
| pm_sleep | input | 1 | Chip is in sleep mode; monitoring suspended |
| irq_en | input | 1 | Failure interrupt enable |
| flag_clr | input | 1 | Single-cycle pulse clearing the failure flag |
| ret_req | input | 1 | Single-cycle software request to go back to the primary clock |
| sys_clk | output | 1 | Selected system clock |
| fail_flag | output | 1 | Latched failure flag |
| fail_irq | output | 1 | Failure interrupt request |
| wake_req | output | 1 | Request to leave idle or sleep on a failure |

## Verification
Two pairs of events can land in one reference cycle. In the first, `flag_clr` arrives while the primary clock is still dead, so the timeout condition is still true. The bench pulses the clear with the primary held stopped and expects the flag still set on the next cycle. In the second, `flag_clr` and `ret_req` are pulsed together after the primary has resumed. Here the request has to lose to the flag that is still set, so the bench expects the flag cleared but `sys_clk` still following `ref_clk` thirty cycles later.

// File: rtl/fsafe_pkg.sv
`timescale 1ns/1ps
package fsafe_pkg;
  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_RC   = 2'd1,
    SRC_IRC  = 2'd2,
    SRC_XTAL = 2'd3
  } pri_kind_e;

  // Crystal sources need a start-up run before monitoring (R3)
  function automatic logic needs_startup(input logic [1:0] kind);
    return kind == SRC_XTAL;
  endfunction
endpackage

// File: rtl/fsafe_sync.sv
`timescale 1ns/1ps
module fsafe_sync #(
  parameter int STAGES   = 2,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  logic [STAGES-1:0] nxt;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign nxt[i] = d;
      end else begin : g_rest
        assign nxt[i] = sh[i-1];
      end
    end
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n) sh <= '0;
        else        sh <= nxt;
      end
    end else begin : g_pos
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) sh <= '0;
        else        sh <= nxt;
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/fsafe_edge_watch.sv
`timescale 1ns/1ps
module fsafe_edge_watch #(
  parameter int TMO_CYC     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic pri_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_on,
  output logic pri_edge,
  output logic timeout
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic          pri_tog;
  logic          tog_s;
  logic          tog_d;
  logic [CW-1:0] gap_cnt;

  always_ff @(posedge pri_clk or negedge rst_n) begin
    if (!rst_n) pri_tog <= 1'b0;
    else        pri_tog <= ~pri_tog;
  end

  fsafe_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_tog_sync (
    .clk(ref_clk), .clr_n(rst_n), .d(pri_tog), .q(tog_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tog_d <= 1'b0;
    else        tog_d <= tog_s;
  end

  assign pri_edge = tog_s ^ tog_d;

  // Silence counter, saturating at the window length (R4)
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                             gap_cnt <= '0;
    else if (pri_edge || !mon_on)           gap_cnt <= '0;
    else if (gap_cnt != CW'(TMO_CYC))       gap_cnt <= gap_cnt + CW'(1);
  end

  // No detection while disarmed, e.g. in sleep (R11)
  assign timeout = mon_on && (gap_cnt == CW'(TMO_CYC));
endmodule

// File: rtl/fsafe_arm.sv
`timescale 1ns/1ps
module fsafe_arm
  import fsafe_pkg::*;
#(
  parameter int SU_CYC = 1024
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [1:0] pri_kind,
  input  logic       pm_sleep,
  input  logic       pri_edge,
  output logic       mon_on
);
  localparam int SW = $clog2(SU_CYC + 1);

  logic [SW-1:0] su_cnt;
  logic          su_done;

  // Start-up run restarts on reset and on every sleep period (R3)
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                                su_cnt <= '0;
    else if (pm_sleep)                         su_cnt <= '0;
    else if (pri_edge && su_cnt != SW'(SU_CYC)) su_cnt <= su_cnt + SW'(1);
  end

  assign su_done = (su_cnt == SW'(SU_CYC));
  // R2: non-crystal kinds are armed at once
  assign mon_on  = !pm_sleep && (!needs_startup(pri_kind) || su_done);
endmodule

// File: rtl/fsafe_clk_mux.sv
`timescale 1ns/1ps
module fsafe_clk_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic pri_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic want_pri,
  input  logic kill_pri,
  output logic sys_clk,
  output logic en_pri,
  output logic en_ref
);
  logic pri_clr_n;
  logic pri_d;
  logic ref_d;

  // A dead primary cannot clock its own gate off: clear it directly (R5)
  assign pri_clr_n = rst_n & ~kill_pri;

  // Each side enables only after seeing the other side off (R12)
  assign pri_d = want_pri & ~en_ref;
  assign ref_d = ~want_pri & ~en_pri;

  fsafe_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_pri_gate (
    .clk(pri_clk), .clr_n(pri_clr_n), .d(pri_d), .q(en_pri)
  );

  fsafe_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_ref_gate (
    .clk(ref_clk), .clr_n(rst_n), .d(ref_d), .q(en_ref)
  );

  assign sys_clk = (pri_clk & en_pri) | (ref_clk & en_ref);
endmodule

// File: rtl/fsafe_clk_guard.sv
`timescale 1ns/1ps
module fsafe_clk_guard #(
  parameter int TMO_CYC     = 64,
  parameter int SU_CYC      = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       pri_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [1:0] pri_kind,
  input  logic       pm_idle,
  input  logic       pm_sleep,
  input  logic       irq_en,
  input  logic       flag_clr,
  input  logic       ret_req,
  output logic       sys_clk,
  output logic       fail_flag,
  output logic       fail_irq,
  output logic       wake_req
);
  logic pri_edge;
  logic mon_on;
  logic tmo;
  logic fail_q;
  logic want_pri_q;
  logic en_pri;
  logic en_ref;

  fsafe_edge_watch #(.TMO_CYC(TMO_CYC), .SYNC_STAGES(SYNC_STAGES)) u_watch (
    .pri_clk(pri_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .mon_on(mon_on), .pri_edge(pri_edge), .timeout(tmo)
  );

  fsafe_arm #(.SU_CYC(SU_CYC)) u_arm (
    .ref_clk(ref_clk), .rst_n(rst_n), .pri_kind(pri_kind),
    .pm_sleep(pm_sleep), .pri_edge(pri_edge), .mon_on(mon_on)
  );

  // R9: a live timeout outweighs a clear; R6: otherwise the flag holds
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= tmo | (fail_q & ~flag_clr);
  end

  // R8/R10: a return is honoured only with the flag already clear
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                  want_pri_q <= 1'b1;
    else if (tmo)                want_pri_q <= 1'b0;
    else if (ret_req && !fail_q) want_pri_q <= 1'b1;
  end

  fsafe_clk_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .pri_clk(pri_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .want_pri(want_pri_q), .kill_pri(fail_q),
    .sys_clk(sys_clk), .en_pri(en_pri), .en_ref(en_ref)
  );

  assign fail_flag = fail_q;
  assign fail_irq  = fail_q & irq_en;               // R7
  assign wake_req  = fail_irq & (pm_idle | pm_sleep);
endmodule

// File: rtl/fsafe_clk_guard_chk.sv
`timescale 1ns/1ps
module fsafe_clk_guard_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic pm_sleep,
  input logic irq_en,
  input logic flag_clr,
  input logic fail_flag,
  input logic fail_irq,
  input logic wake_req,
  input logic want_pri,
  input logic timeout,
  input logic en_pri,
  input logic en_ref
);
  a_r6_flag_latched: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_flag && !flag_clr |=> fail_flag);

  a_r8_no_return_while_flagged: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_flag |=> !want_pri);

  a_r9_clear_takes: assert property (@(posedge ref_clk) disable iff (!rst_n)
    flag_clr && !timeout |=> !fail_flag);

  a_r11_quiet_in_sleep: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pm_sleep && !fail_flag |=> !fail_flag);

  a_r7_masked_requests: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !irq_en |-> !fail_irq && !wake_req);

  a_r12_one_source: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(en_pri && en_ref));
endmodule

bind fsafe_clk_guard fsafe_clk_guard_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .pm_sleep(pm_sleep), .irq_en(irq_en),
  .flag_clr(flag_clr), .fail_flag(fail_flag), .fail_irq(fail_irq),
  .wake_req(wake_req), .want_pri(want_pri_q), .timeout(tmo),
  .en_pri(en_pri), .en_ref(en_ref)
);

// File: tb/tb_fsafe_clk_guard.sv
`timescale 1ns/100ps
module tb_fsafe_clk_guard;
  localparam real CLK_PERIOD = 10.0;
  localparam real PRI_HALF   = 15.0;

  logic       pri_clk, ref_clk, rst_n;
  logic [1:0] pri_kind;
  logic       pm_idle, pm_sleep, irq_en, flag_clr, ret_req;
  logic       sys_clk, fail_flag, fail_irq, wake_req;
  logic       pri_run;

  int  checks = 0;
  int  errors = 0;
  bit  pw_watch = 0;
  int  pw_bad = 0;
  real pw_last = 0.0;

  fsafe_clk_guard dut (
    .pri_clk(pri_clk), .ref_clk(ref_clk), .rst_n(rst_n), .pri_kind(pri_kind),
    .pm_idle(pm_idle), .pm_sleep(pm_sleep), .irq_en(irq_en),
    .flag_clr(flag_clr), .ret_req(ret_req), .sys_clk(sys_clk),
    .fail_flag(fail_flag), .fail_irq(fail_irq), .wake_req(wake_req)
  );

  initial begin
    ref_clk = 1'b0;
    forever #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;
  end

  initial begin
    pri_clk = 1'b0;
    #7;
    forever begin
      #(PRI_HALF);
      if (pri_run) pri_clk = ~pri_clk;
      else         pri_clk = 1'b0;
    end
  end

  // Pulse-width monitor on the system clock (R12)
  always @(sys_clk) begin
    if (pw_watch && ($realtime - pw_last) < (CLK_PERIOD / 2.0 - 0.1)) pw_bad++;
    pw_last = $realtime;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic check_src(input bit want_ref, input string what);
    int mis = 0;
    @(negedge ref_clk);
    #1.5;
    for (int i = 0; i < 30; i++) begin
      if (sys_clk !== (want_ref ? ref_clk : pri_clk)) mis++;
      #2;
    end
    check(mis == 0, what, mis, 0);
  endtask

  task automatic do_reset(input logic [1:0] kind);
    rst_n = 1'b0; pri_kind = kind; pri_run = 1'b1;
    pm_idle = 1'b0; pm_sleep = 1'b0; irq_en = 1'b0;
    flag_clr = 1'b0; ret_req = 1'b0;
    tick(5);
    rst_n = 1'b1;
  endtask

  task automatic pulse_clr_ret(input bit c, input bit r);
    flag_clr = c; ret_req = r;
    tick(1);
    flag_clr = 1'b0; ret_req = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(2'd0);
    tick(20);
    check(fail_flag == 1'b0, "R1 flag after reset", fail_flag, 0);
    check(fail_irq == 1'b0 && wake_req == 1'b0, "R1 irq/wake after reset",
          {fail_irq, wake_req}, 0);
    check_src(1'b0, "R1 sys_clk follows primary after reset");
  endtask

  task automatic t_failover_and_return;
    do_reset(2'd1);
    irq_en = 1'b1;
    tick(10);
    pw_watch = 1'b1; pw_last = $realtime; pw_bad = 0;
    pri_run = 1'b0;
    tick(40);
    check(fail_flag == 1'b0, "R4 no failure after 40-cycle gap", fail_flag, 0);
    tick(50);
    check(fail_flag == 1'b1, "R2/R4 failure after silence window", fail_flag, 1);
    check(fail_irq == 1'b1, "R7 irq with enable", fail_irq, 1);
    check(wake_req == 1'b0, "R7 no wake outside low-power mode", wake_req, 0);
    pm_idle = 1'b1;
    tick(1);
    check(wake_req == 1'b1, "R7 wake in idle with enable", wake_req, 1);
    pm_idle = 1'b0;
    tick(10);
    check_src(1'b1, "R5 sys_clk on reference after failure");
    // Clear while primary still dead: timeout must win (R9)
    pulse_clr_ret(1'b1, 1'b0);
    check(fail_flag == 1'b1, "R9 timeout beats clear in same cycle", fail_flag, 1);
    pri_run = 1'b1;
    tick(50);
    check(fail_flag == 1'b1, "R6 flag stays after primary resumes", fail_flag, 1);
    check_src(1'b1, "R6 stays on reference after primary resumes");
    pulse_clr_ret(1'b0, 1'b1);
    tick(30);
    check_src(1'b1, "R8 return request ignored while flagged");
    pulse_clr_ret(1'b1, 1'b1);
    check(fail_flag == 1'b0, "R9 clear drops flag", fail_flag, 0);
    tick(30);
    check_src(1'b1, "R8 request in clear cycle ignored");
    pulse_clr_ret(1'b0, 1'b1);
    tick(30);
    check_src(1'b0, "R10 back on primary after clear and request");
    check(fail_flag == 1'b0, "R10 flag stays clear on return", fail_flag, 0);
    pw_watch = 1'b0;
    check(pw_bad == 0, "R12 no short sys_clk phase across handovers", pw_bad, 0);
  endtask

  task automatic t_masked;
    do_reset(2'd2);
    irq_en = 1'b0; pm_idle = 1'b1;
    tick(10);
    pri_run = 1'b0;
    tick(90);
    check(fail_flag == 1'b1, "R7 failure flagged with irq disabled", fail_flag, 1);
    check(fail_irq == 1'b0 && wake_req == 1'b0, "R7 no irq/wake when disabled",
          {fail_irq, wake_req}, 0);
    check_src(1'b1, "R7 keeps running on reference in idle");
  endtask

  task automatic t_sleep;
    do_reset(2'd0);
    tick(10);
    pm_sleep = 1'b1;
    tick(2);
    pri_run = 1'b0;
    tick(150);
    check(fail_flag == 1'b0, "R11 no detection in sleep", fail_flag, 0);
    pri_run = 1'b1;
    tick(10);
    pm_sleep = 1'b0;
    tick(20);
    pri_run = 1'b0;
    tick(90);
    check(fail_flag == 1'b1, "R11 detection re-armed after sleep", fail_flag, 1);
  endtask

  task automatic t_crystal;
    do_reset(2'd3);
    tick(900);
    pri_run = 1'b0;
    tick(150);
    check(fail_flag == 1'b0, "R3 no detection before start-up count", fail_flag, 0);
    pri_run = 1'b1;
    tick(2400);
    pri_run = 1'b0;
    tick(90);
    check(fail_flag == 1'b1, "R3 detection after start-up count", fail_flag, 1);
    do_reset(2'd3);
    tick(3300);
    pm_sleep = 1'b1;
    tick(5);
    pm_sleep = 1'b0;
    tick(100);
    pri_run = 1'b0;
    tick(150);
    check(fail_flag == 1'b0, "R3 start-up count restarts after sleep", fail_flag, 0);
  endtask

  initial begin
    rst_n = 1'b0; pri_run = 1'b1; pri_kind = 2'd0;
    pm_idle = 1'b0; pm_sleep = 1'b0; irq_en = 1'b0;
    flag_clr = 1'b0; ret_req = 1'b0;
    t_reset();
    t_failover_and_return();
    t_masked();
    t_sleep();
    t_crystal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule